// File: doc/BRIEF.md
# Four-Channel Serial DAC Write Sequencer

This block drives the write side of a four-channel, 8-bit serial DAC. It generates a shift clock, a serial data line, a latch strobe and an output-apply strobe from a fast system clock. A host hands it one request at a time through a valid/ready handshake. A request is either a channel write or a "commit all" command. A channel write carries a 2-bit channel number, an 8-bit code, a range bit and an update mode. In immediate mode the new code reaches the output as soon as it is latched. In deferred mode the code is parked inside the converter until a later commit.

Every minimum timing figure the converter needs is given as a parameter in nanoseconds, together with the system clock frequency and the ceiling on the shift-clock rate. Each figure is turned into a whole number of system clock cycles at elaboration, always rounding up. Only one request is in flight at a time. A one-cycle done pulse marks the end of each request, and the block is ready again on the next cycle. A typical use is to write four channels in deferred mode and then issue one commit, so that all outputs change together.

Top module: `qdac_host`

## Requirements
- R1: A write shifts out 11 bits, most significant first, in this order: channel bit 1, channel bit 0, range bit, then code bits 7 down to 0.
- R2: The shift clock idles high. A write produces exactly 11 falling edges. Every low phase, and every high phase that starts with a rising edge, lasts HALF cycles, where HALF is the larger of ceil(SYS_HZ / (2*SCLK_HZ)) and the setup figure in cycles.
- R3: The data line changes only when the shift clock rises, never while it is low. It is held low whenever no bits are being shifted.
- R4: The latch strobe falls exactly HALF + TSU cycles after the 11th falling clock edge, where TSU is the setup figure in cycles. The shift clock is high whenever the latch strobe is low.
- R5: The latch strobe stays low for TLW cycles, the latch-width figure rounded up to cycles.
- R6: Done pulses for one cycle, TSU cycles after the latch strobe rises. At that moment both the latch strobe and the shift clock are high.
- R7: An immediate write drives the apply strobe low from the cycle after acceptance until done. The apply strobe is high again when done pulses. It falls only on the cycle right after a request is accepted.
- R8: A deferred write keeps the apply strobe high for the whole transfer.
- R9: A commit drives the apply strobe low for exactly TAW cycles, the apply-width figure rounded up to cycles. It produces no shift-clock or latch activity, and it ignores the channel, code, range and mode inputs.
- R10: Ready is high only when idle and is low from the cycle after acceptance through the done cycle. A valid pulse while busy is ignored: it does not change the word in flight and starts no further transfer.
- R11: During and after reset: shift clock high, latch strobe high, apply strobe high, data low, ready high, done low.
- R12: Every nanosecond figure is converted to cycles rounding up. For example, a 245 ns latch width at 100 MHz gives 25 cycles, and a 3 MHz shift-clock ceiling at 100 MHz gives a 17-cycle half period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle; the request is taken on this edge |
| req_commit | input | 1 | 1 = commit all channels; 0 = channel write |
| req_defer | input | 1 | For writes: 1 = deferred, 0 = immediate |
| req_chan | input | 2 | Channel number |
| req_range | input | 1 | Output range bit (0 = 1x, 1 = 2x) |
| req_code | input | 8 | Converter code |
| done | output | 1 | One-cycle pulse when a request completes |
| dac_sclk | output | 1 | Serial shift clock; data is taken on its falling edge |
| dac_sdata | output | 1 | Serial data |
| dac_latch_n | output | 1 | Latch strobe, active low |
| dac_apply_n | output | 1 | Output apply strobe, active low |

## Verification
The bench builds the block with SYS_HZ = 100 MHz, SCLK_HZ = 3 MHz and a 245 ns latch width. Neither figure divides evenly, so both the clock half period (16.7 cycles, giving 17) and the latch width (24.5 cycles, giving 25) must round up, which exercises the rounding. The short half period keeps each transfer near 400 cycles. That makes it cheap to cover all four channels, both range values, both modes, a deferred batch ending in a commit, and a busy-time valid pulse. All phase lengths are measured at the pins against values the bench computes for itself.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BHI,
    ST_BLO,
    ST_GAP,
    ST_LLO,
    ST_LHI,
    ST_CMT,
    ST_DONE
  } qdac_state_e;

  // nanoseconds to system cycles, rounded up, at least one cycle
  function automatic int qdac_ns2cyc(longint hz, longint ns);
    longint c;
    c = (hz * ns + 64'sd999_999_999) / 64'sd1_000_000_000;
    if (c < 64'sd1) c = 64'sd1;
    return int'(c);
  endfunction

  // half period of the shift clock, rounded up, never shorter than floor_c
  function automatic int qdac_half(longint hz, longint sclk_hz, int floor_c);
    longint c;
    c = (hz + 64'sd2 * sclk_hz - 64'sd1) / (64'sd2 * sclk_hz);
    if (c < longint'(floor_c)) c = longint'(floor_c);
    return int'(c);
  endfunction

  function automatic int qdac_max(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/qdac_tick.sv
module qdac_tick #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val - CW'(1);
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end

  assign zero = (cnt == '0);

  // R2: an expired timer stays expired until reloaded
  p_tick_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);

endmodule

// File: rtl/qdac_shreg.sv
module qdac_shreg #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         shift,
  output logic         msb,
  output logic         last
);
  localparam int LW = $clog2(W + 1);

  logic [W-1:0]  sh;
  logic [LW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      left <= '0;
    end else if (load) begin
      sh   <= load_word;
      left <= LW'(W - 1);
    end else if (shift) begin
      sh   <= {sh[W-2:0], 1'b0};
      left <= left - LW'(1);
    end
  end

  assign msb  = sh[W-1];
  assign last = (left == '0);

  // R1: never shift beyond the final bit of a word
  p_no_overshift_r1: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> !last);

endmodule

// File: rtl/qdac_host.sv
module qdac_host #(
  parameter int SYS_HZ   = 100_000_000,
  parameter int SCLK_HZ  = 1_000_000,
  parameter int SETUP_NS = 50,
  parameter int LOAD_NS  = 250,
  parameter int APPLY_NS = 250,
  parameter int CHAN_W   = 2,
  parameter int CODE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_commit,
  input  logic              req_defer,
  input  logic [CHAN_W-1:0] req_chan,
  input  logic              req_range,
  input  logic [CODE_W-1:0] req_code,
  output logic              done,
  output logic              dac_sclk,
  output logic              dac_sdata,
  output logic              dac_latch_n,
  output logic              dac_apply_n
);
  import qdac_pkg::*;

  localparam int WORD_W = CHAN_W + 1 + CODE_W;
  localparam int T_SU   = qdac_ns2cyc(SYS_HZ, SETUP_NS);
  localparam int T_HALF = qdac_half(SYS_HZ, SCLK_HZ, T_SU);
  localparam int T_LW   = qdac_ns2cyc(SYS_HZ, LOAD_NS);
  localparam int T_AW   = qdac_ns2cyc(SYS_HZ, APPLY_NS);
  localparam int T_MAX  = qdac_max(qdac_max(T_SU, T_HALF), qdac_max(T_LW, T_AW));
  localparam int CNT_W  = $clog2(T_MAX + 1);

  qdac_state_e       st, st_n;
  logic              t_load, t_zero;
  logic [CNT_W-1:0]  t_val;
  logic              sh_load, sh_shift, sh_msb, sh_last;

  // named events
  logic accept;     // request taken this edge
  logic finishing;  // final timed phase expires this edge

  assign accept    = req_valid && req_ready;
  assign finishing = t_zero && (st == ST_LHI || st == ST_CMT);

  qdac_tick #(.CW(CNT_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  qdac_shreg #(.W(WORD_W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .load(sh_load),
    .load_word({req_chan, req_range, req_code}),
    .shift(sh_shift), .msb(sh_msb), .last(sh_last)
  );

  always_comb begin
    st_n     = st;
    t_load   = 1'b0;
    t_val    = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    case (st)
      ST_IDLE: if (accept) begin
        t_load = 1'b1;
        if (req_commit) begin
          st_n  = ST_CMT;
          t_val = CNT_W'(T_AW);
        end else begin
          st_n    = ST_BHI;
          t_val   = CNT_W'(T_HALF);
          sh_load = 1'b1;
        end
      end
      ST_BHI: if (t_zero) begin
        st_n = ST_BLO; t_load = 1'b1; t_val = CNT_W'(T_HALF);
      end
      ST_BLO: if (t_zero) begin
        t_load = 1'b1;
        if (sh_last) begin
          st_n = ST_GAP; t_val = CNT_W'(T_SU);
        end else begin
          st_n = ST_BHI; t_val = CNT_W'(T_HALF); sh_shift = 1'b1;
        end
      end
      ST_GAP: if (t_zero) begin
        st_n = ST_LLO; t_load = 1'b1; t_val = CNT_W'(T_LW);
      end
      ST_LLO: if (t_zero) begin
        st_n = ST_LHI; t_load = 1'b1; t_val = CNT_W'(T_SU);
      end
      ST_LHI:  if (t_zero) st_n = ST_DONE;
      ST_CMT:  if (t_zero) st_n = ST_DONE;
      ST_DONE: st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dac_apply_n <= 1'b1;
    else if (accept)    dac_apply_n <= !req_commit && req_defer;
    else if (finishing) dac_apply_n <= 1'b1;
  end

  assign req_ready   = (st == ST_IDLE);
  assign done        = (st == ST_DONE);
  assign dac_sclk    = (st != ST_BLO);
  assign dac_latch_n = (st != ST_LLO);
  assign dac_sdata   = (st == ST_BHI || st == ST_BLO) ? sh_msb : 1'b0;

  // R10: busy from the cycle after acceptance
  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  // R3: data holds steady while the shift clock stays low
  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_sclk && !$past(dac_sclk)) |-> $stable(dac_sdata));
  // R4: latch strobe only while the shift clock is high
  p_latch_clk_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_latch_n |-> dac_sclk);
  // R6: done is a single cycle with both strobes released
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (dac_latch_n && dac_sclk && dac_apply_n));
  // R7: the apply strobe falls only right after an acceptance
  p_apply_fall_on_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_apply_n) |-> $past(accept));
  // R9: a commit keeps clock and latch idle
  p_commit_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CMT) |-> (dac_sclk && dac_latch_n && !dac_apply_n));

endmodule

// File: tb/qdac_host_bench.sv
module qdac_host_bench;

  function automatic int cdiv(int a, int b);
    return (a + b - 1) / b;
  endfunction

  // own restatement of the cycle figures at 100 MHz (100 cycles per us)
  localparam int E_SU   = cdiv(50 * 100, 1000);
  localparam int E_HRAW = cdiv(100_000_000, 2 * 3_000_000);
  localparam int E_HALF = (E_HRAW > E_SU) ? E_HRAW : E_SU;
  localparam int E_LW   = cdiv(245 * 100, 1000);
  localparam int E_AW   = cdiv(250 * 100, 1000);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_commit = 1'b0, req_defer = 1'b0, req_range = 1'b0;
  logic [1:0] req_chan = '0;
  logic [7:0] req_code = '0;
  logic req_ready, done, dac_sclk, dac_sdata, dac_latch_n, dac_apply_n;

  always #5 clk = ~clk;

  qdac_host #(
    .SYS_HZ(100_000_000), .SCLK_HZ(3_000_000), .SETUP_NS(50),
    .LOAD_NS(245), .APPLY_NS(250), .CHAN_W(2), .CODE_W(8)
  ) u_qdac_host (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_commit(req_commit), .req_defer(req_defer), .req_chan(req_chan),
    .req_range(req_range), .req_code(req_code), .done(done),
    .dac_sclk(dac_sclk), .dac_sdata(dac_sdata), .dac_latch_n(dac_latch_n),
    .dac_apply_n(dac_apply_n)
  );

  int tests = 0, fails = 0;

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // pin monitor, sampled on the falling clock edge
  int cyc = 0;
  int falls, lo_bad, hi_bad, data_bad, first_lo, latch_falls;
  int t_fall, t_rise, t_lfall, gap, lw, rise_done, apply_lo, rdy_hi, done_cnt;
  bit have_rise, busy, acc_seen;
  logic [10:0] word_cap;
  logic p_sclk = 1'b1, p_sdata = 1'b0, p_latch = 1'b1;

  always @(posedge clk) acc_seen <= req_valid && req_ready;

  task automatic clear_mon();
    falls = 0; lo_bad = 0; hi_bad = 0; data_bad = 0; first_lo = 0;
    latch_falls = 0; gap = 0; lw = 0; rise_done = 0; apply_lo = 0;
    rdy_hi = 0; done_cnt = 0; have_rise = 0; busy = 0; word_cap = '0;
    t_fall = 0; t_rise = 0; t_lfall = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
    if (acc_seen) busy = 1;
    if (p_sclk && !dac_sclk) begin
      falls++;
      word_cap = {word_cap[9:0], dac_sdata};
      if (have_rise && (cyc - t_rise) != E_HALF) hi_bad++;
      t_fall = cyc;
    end
    if (!p_sclk && dac_sclk) begin
      if ((cyc - t_fall) != E_HALF) lo_bad++;
      if (first_lo == 0) first_lo = cyc - t_fall;
      t_rise = cyc; have_rise = 1;
    end
    if (!p_sclk && !dac_sclk && dac_sdata != p_sdata) data_bad++;
    if (p_latch && !dac_latch_n) begin
      latch_falls++; t_lfall = cyc; gap = cyc - t_fall;
    end
    if (!p_latch && dac_latch_n) begin
      lw = cyc - t_lfall; rise_done = cyc;
    end
    if (done) begin
      done_cnt++;
      if (busy) rise_done = cyc - rise_done;
      busy = 0;
    end
    if (busy && !dac_apply_n) apply_lo++;
    if (busy && req_ready) rdy_hi++;
    p_sclk = dac_sclk; p_sdata = dac_sdata; p_latch = dac_latch_n;
  end

  task automatic send(logic [12:0] v);
    @(negedge clk); #1;
    clear_mon();
    {req_commit, req_defer, req_chan, req_range, req_code} = v;
    req_valid = 1'b1;
    @(negedge clk); #1;
    req_valid = 1'b0;
    {req_commit, req_defer, req_chan, req_range, req_code} = 13'h1FFF;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk); #1;
      if (done_cnt > 0) break;
    end
  endtask

  // {commit, defer, chan[1:0], range, code[7:0]}
  localparam logic [12:0] VEC [6] = '{
    {1'b0, 1'b0, 2'd0, 1'b0, 8'h00},
    {1'b0, 1'b0, 2'd3, 1'b1, 8'hFF},
    {1'b0, 1'b1, 2'd1, 1'b0, 8'hA5},
    {1'b0, 1'b1, 2'd2, 1'b1, 8'h3C},
    {1'b1, 1'b0, 2'd0, 1'b0, 8'h00},
    {1'b0, 1'b0, 2'd2, 1'b0, 8'h81}
  };

  localparam int E_XFER = 22 * E_HALF + E_SU + E_LW + E_SU;

  initial begin
    clear_mon();
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 sclk", dac_sclk, 1);
    chk("R11 latch", dac_latch_n, 1);
    chk("R11 apply", dac_apply_n, 1);
    chk("R11 sdata", dac_sdata, 0);
    chk("R11 ready", req_ready, 1);
    chk("R11 done", done, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 ready after release", req_ready, 1);

    for (int k = 0; k < 6; k++) begin
      send(VEC[k]);
      wait_done();
      chk("R6 done seen", done_cnt, 1);
      chk("R10 ready low while busy", rdy_hi, 0);
      if (VEC[k][12]) begin
        chk("R9 commit apply width", apply_lo, E_AW);
        chk("R9 commit no clock", falls, 0);
        chk("R9 commit no latch", latch_falls, 0);
      end else begin
        chk("R1 word", int'(word_cap), int'(VEC[k][10:0]));
        chk("R2 falling edges", falls, 11);
        chk("R2 low phases", lo_bad, 0);
        chk("R2 high phases", hi_bad, 0);
        chk("R3 data stable while low", data_bad, 0);
        chk("R4 fall to latch", gap, E_HALF + E_SU);
        chk("R5 latch width", lw, E_LW);
        chk("R6 latch rise to done", rise_done, E_SU);
        if (VEC[k][11]) chk("R8 deferred apply low", apply_lo, 0);
        else            chk("R7 immediate apply low", apply_lo, E_XFER);
      end
      repeat (2) @(negedge clk);
      chk("R7 apply high after done", dac_apply_n, 1);
      chk("R3 data idle low", dac_sdata, 0);
    end

    // R12: rounding up of fractional cycle counts
    send({1'b0, 1'b0, 2'd1, 1'b1, 8'h5A});
    wait_done();
    chk("R12 half period 17", first_lo, 17);
    chk("R12 latch width 25", lw, 25);

    // R10: valid pulse while busy is ignored
    send({1'b0, 1'b1, 2'd0, 1'b1, 8'hC3});
    repeat (40) @(negedge clk);
    #1;
    req_valid = 1'b1; req_commit = 1'b0; req_defer = 1'b0;
    req_chan = 2'd3; req_range = 1'b0; req_code = 8'h11;
    @(negedge clk); #1;
    req_valid = 1'b0;
    wait_done();
    chk("R10 busy word unchanged", int'(word_cap), int'({2'd0, 1'b1, 8'hC3}));
    chk("R10 busy pulse no apply", apply_lo, 0);
    @(negedge clk); #1;
    clear_mon();
    repeat (60) @(negedge clk);
    chk("R10 no second transfer", falls, 0);
    chk("R10 no second done", done_cnt, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule